// File: doc/BRIEF.md
# UART FIFO DMA Request Generator

This block turns the fill levels of a UART's receive and transmit FIFOs into request strobes for a DMA controller. Each direction has two request lines: a burst request, raised when the FIFO can deliver (receive) or absorb (transmit) a whole burst at the selected watermark, and a single-transfer request, raised when some data or space exists but not enough for a burst. Only one of the two is active at a time in each direction.

A 2-bit watermark selection sets the burst size for both directions together. Each direction has its own enable. When an acknowledge arrives from the DMA, that direction's requests drop for one cycle and are then recomputed from the updated FIFO count. A gating option holds the receive requests low while any UART error flag (parity, break, framing, overrun) is pending. The transmit requests ignore this gating.

All request outputs are registered. Each output reflects the inputs sampled at the previous rising clock edge.

Top module: `uart_dma_req`

## Requirements
- R1: While synchronous active-low reset `rst_n` is low at a clock edge, all four request outputs are 0 after that edge.
- R2: Receive burst length is 2 for watermark code 2'b00, 4 for 2'b01, 6 for 2'b10, and 4 for 2'b11. With receive enabled, no acknowledge and no gating, `rx_burst_req` is 1 one cycle after `rx_count` is at or above that length.
- R3: Under the same conditions, `rx_single_req` is 1 one cycle after `rx_count` is between 1 and the burst length minus 1. Both receive outputs are 0 when `rx_count` is 0.
- R4: Transmit burst length (empty slots in an 8-deep FIFO) is 6 for code 2'b00, 4 for 2'b01, 2 for 2'b10, and 4 for 2'b11. With transmit enabled and no acknowledge, `tx_burst_req` is 1 one cycle after (8 - `tx_count`) is at or above that length.
- R5: Under the same conditions, `tx_single_req` is 1 one cycle after the free space is between 1 and the burst length minus 1. Both transmit outputs are 0 when `tx_count` is 8.
- R6: In each direction, the single and burst requests are never both 1.
- R7: When a direction's DMA enable is 0, both of its request outputs are 0 one cycle later, whatever the FIFO level.
- R8: An acknowledge sampled at an edge forces that direction's requests to 0 after the edge. At the next edge they are recomputed from the count sampled there.
- R9: With `err_gate_en` = 1 and any bit of `err_flags` set, both receive requests are 0 one cycle later. They recover one cycle after the flags clear. The transmit requests are unaffected.
- R10: With `err_gate_en` = 0, `err_flags` has no effect on the receive requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_dma_en | input | 1 | Receive DMA enable |
| tx_dma_en | input | 1 | Transmit DMA enable |
| err_gate_en | input | 1 | Suppress receive requests on error flags |
| wmark_sel | input | 2 | Watermark code: 00 quarter, 01 half, 10 three-quarter, 11 half |
| rx_count | input | 4 | Receive FIFO fill count, 0..8 |
| tx_count | input | 4 | Transmit FIFO fill count, 0..8 |
| err_flags | input | 4 | UART error flags (parity, break, framing, overrun), any order |
| rx_ack | input | 1 | DMA acknowledge, receive direction |
| tx_ack | input | 1 | DMA acknowledge, transmit direction |
| rx_single_req | output | 1 | Receive single-transfer request |
| rx_burst_req | output | 1 | Receive burst request |
| tx_single_req | output | 1 | Transmit single-transfer request |
| tx_burst_req | output | 1 | Transmit burst request |

## Verification
The hardest case to reach is an acknowledge that arrives in the same cycle as a count change, with the FIFO level crossing a burst boundary. A stale request could then survive the acknowledge or repeat for data already moved. The bench holds the count above the burst length and pulses the acknowledge. In that same cycle it lowers the count below the boundary. It then checks that the requests are zero for exactly one cycle and come back as a single request. The error gating check sets each flag bit in turn while the transmit FIFO is partly empty. This shows that the receive requests drop while the transmit requests keep their value.

// File: rtl/uart_dma_pkg.sv
package uart_dma_pkg;

   typedef enum logic [1:0] {
      WM_QUARTER = 2'b00,
      WM_HALF    = 2'b01,
      WM_3QTR    = 2'b10,
      WM_RSVD    = 2'b11
   } wmark_e;

   typedef struct packed {
      logic single;
      logic burst;
   } dma_req_t;

endpackage

// File: rtl/uart_dma_wmark_dec.sv
module uart_dma_wmark_dec
   import uart_dma_pkg::*;
#(
   parameter int DEPTH = 8,
   parameter int CNT_W = $clog2(DEPTH + 1)
) (
   input  wmark_e             sel,
   output logic [CNT_W-1:0]   rx_thr,
   output logic [CNT_W-1:0]   tx_thr
);
   localparam int QTR = DEPTH / 4;
   localparam logic [CNT_W-1:0] THR_Q  = CNT_W'(QTR);
   localparam logic [CNT_W-1:0] THR_H  = CNT_W'(2 * QTR);
   localparam logic [CNT_W-1:0] THR_3Q = CNT_W'(3 * QTR);
   localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

   always_comb begin
      unique case (sel)
         WM_QUARTER: rx_thr = THR_Q;
         WM_3QTR:    rx_thr = THR_3Q;
         default:    rx_thr = THR_H;
      endcase
      tx_thr = DEPTH_C - rx_thr;
   end
endmodule

// File: rtl/uart_dma_err_gate.sv
module uart_dma_err_gate #(
   parameter int NUM_ERR = 4
) (
   input  logic               gate_en,
   input  logic [NUM_ERR-1:0] flags,
   output logic               suppress
);
   always_comb suppress = gate_en & (|flags);
endmodule

// File: rtl/uart_dma_chan.sv
module uart_dma_chan
   import uart_dma_pkg::*;
#(
   parameter int DEPTH = 8,
   parameter int CNT_W = $clog2(DEPTH + 1),
   parameter bit IS_TX = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             suppress,
   input  logic             ack,
   input  logic [CNT_W-1:0] count,
   input  logic [CNT_W-1:0] thr,
   output dma_req_t         req
);
   localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

   logic [CNT_W-1:0] avail;
   dma_req_t         req_d;

   generate
      if (IS_TX) begin : g_space
         always_comb avail = (count >= DEPTH_C) ? '0 : (DEPTH_C - count);
      end else begin : g_data
         always_comb avail = (count > DEPTH_C) ? DEPTH_C : count;
      end
   endgenerate

   always_comb begin
      req_d = '0;
      if (en && !suppress && !ack) begin
         req_d.burst  = (avail >= thr);
         req_d.single = (avail != '0) && (avail < thr);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) req <= '0;
      else        req <= req_d;
   end
endmodule

// File: rtl/uart_dma_req.sv
module uart_dma_req
   import uart_dma_pkg::*;
#(
   parameter int DEPTH   = 8,
   parameter int NUM_ERR = 4,
   parameter int CNT_W   = $clog2(DEPTH + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               rx_dma_en,
   input  logic               tx_dma_en,
   input  logic               err_gate_en,
   input  logic [1:0]         wmark_sel,
   input  logic [CNT_W-1:0]   rx_count,
   input  logic [CNT_W-1:0]   tx_count,
   input  logic [NUM_ERR-1:0] err_flags,
   input  logic               rx_ack,
   input  logic               tx_ack,
   output logic               rx_single_req,
   output logic               rx_burst_req,
   output logic               tx_single_req,
   output logic               tx_burst_req
);
   generate
      if (DEPTH < 4 || (DEPTH % 4) != 0) begin : g_bad_depth
         $error("uart_dma_req: DEPTH must be a multiple of 4, at least 4");
      end
      if (NUM_ERR < 1) begin : g_bad_err
         $error("uart_dma_req: NUM_ERR must be at least 1");
      end
      if (CNT_W < $clog2(DEPTH + 1)) begin : g_bad_cnt
         $error("uart_dma_req: CNT_W too narrow for DEPTH");
      end
   endgenerate

   logic [CNT_W-1:0] rx_thr, tx_thr;
   logic             rx_supp;
   dma_req_t         rx_req, tx_req;

   uart_dma_wmark_dec #(.DEPTH(DEPTH), .CNT_W(CNT_W)) i_wmark (
      .sel    (wmark_e'(wmark_sel)),
      .rx_thr (rx_thr),
      .tx_thr (tx_thr)
   );

   uart_dma_err_gate #(.NUM_ERR(NUM_ERR)) i_gate (
      .gate_en  (err_gate_en),
      .flags    (err_flags),
      .suppress (rx_supp)
   );

   uart_dma_chan #(.DEPTH(DEPTH), .CNT_W(CNT_W), .IS_TX(1'b0)) i_rx (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (rx_dma_en),
      .suppress (rx_supp),
      .ack      (rx_ack),
      .count    (rx_count),
      .thr      (rx_thr),
      .req      (rx_req)
   );

   uart_dma_chan #(.DEPTH(DEPTH), .CNT_W(CNT_W), .IS_TX(1'b1)) i_tx (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (tx_dma_en),
      .suppress (1'b0),
      .ack      (tx_ack),
      .count    (tx_count),
      .thr      (tx_thr),
      .req      (tx_req)
   );

   always_comb begin
      rx_single_req = rx_req.single;
      rx_burst_req  = rx_req.burst;
      tx_single_req = tx_req.single;
      tx_burst_req  = tx_req.burst;
   end
endmodule

// File: rtl/uart_dma_req_chk.sv
module uart_dma_req_chk #(
   parameter int CNT_W   = 4,
   parameter int NUM_ERR = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic               rx_dma_en,
   input logic               tx_dma_en,
   input logic               err_gate_en,
   input logic [CNT_W-1:0]   rx_count,
   input logic [CNT_W-1:0]   tx_count,
   input logic [NUM_ERR-1:0] err_flags,
   input logic               rx_ack,
   input logic               tx_ack,
   input logic               rx_single_req,
   input logic               rx_burst_req,
   input logic               tx_single_req,
   input logic               tx_burst_req
);
   AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |=> !rx_single_req && !rx_burst_req && !tx_single_req && !tx_burst_req); // R1
   AST_RX_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n) !(rx_single_req && rx_burst_req)); // R6
   AST_TX_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n) !(tx_single_req && tx_burst_req)); // R6
   AST_RX_DISABLED: assert property (@(posedge clk) disable iff (!rst_n) !rx_dma_en |=> !rx_single_req && !rx_burst_req); // R7
   AST_TX_DISABLED: assert property (@(posedge clk) disable iff (!rst_n) !tx_dma_en |=> !tx_single_req && !tx_burst_req); // R7
   AST_RX_ACK_DROP: assert property (@(posedge clk) disable iff (!rst_n) rx_ack |=> !rx_single_req && !rx_burst_req); // R8
   AST_TX_ACK_DROP: assert property (@(posedge clk) disable iff (!rst_n) tx_ack |=> !tx_single_req && !tx_burst_req); // R8
   AST_RX_ERR_GATE: assert property (@(posedge clk) disable iff (!rst_n) (err_gate_en && (|err_flags)) |=> !rx_single_req && !rx_burst_req); // R9
   AST_RX_EMPTY_IDLE: assert property (@(posedge clk) disable iff (!rst_n) (rx_count == '0) |=> !rx_single_req && !rx_burst_req); // R3
endmodule

bind uart_dma_req uart_dma_req_chk #(.CNT_W(CNT_W), .NUM_ERR(NUM_ERR)) i_chk (
   .clk(clk), .rst_n(rst_n), .rx_dma_en(rx_dma_en), .tx_dma_en(tx_dma_en),
   .err_gate_en(err_gate_en), .rx_count(rx_count), .tx_count(tx_count),
   .err_flags(err_flags), .rx_ack(rx_ack), .tx_ack(tx_ack),
   .rx_single_req(rx_single_req), .rx_burst_req(rx_burst_req),
   .tx_single_req(tx_single_req), .tx_burst_req(tx_burst_req)
);

// File: tb/test_uart_dma_req.sv
`timescale 1ns/1ps
module test_uart_dma_req;
   logic       clk = 1'b0;
   logic       rst_n;
   logic       rx_dma_en, tx_dma_en, err_gate_en;
   logic [1:0] wmark_sel;
   logic [3:0] rx_count, tx_count, err_flags;
   logic       rx_ack, tx_ack;
   logic       rx_single_req, rx_burst_req, tx_single_req, tx_burst_req;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #10 clk = ~clk;

   uart_dma_req i_uart_dma_req (
      .clk(clk), .rst_n(rst_n), .rx_dma_en(rx_dma_en), .tx_dma_en(tx_dma_en),
      .err_gate_en(err_gate_en), .wmark_sel(wmark_sel), .rx_count(rx_count),
      .tx_count(tx_count), .err_flags(err_flags), .rx_ack(rx_ack), .tx_ack(tx_ack),
      .rx_single_req(rx_single_req), .rx_burst_req(rx_burst_req),
      .tx_single_req(tx_single_req), .tx_burst_req(tx_burst_req)
   );

   function automatic int rx_len(input logic [1:0] wm);
      return (wm == 2'b00) ? 2 : (wm == 2'b10) ? 6 : 4;
   endfunction

   function automatic logic [1:0] exp_rx(input int cnt, input logic [1:0] wm);
      logic b;
      b = (cnt >= rx_len(wm));
      return {b, (cnt > 0) && !b};
   endfunction

   function automatic logic [1:0] exp_tx(input int cnt, input logic [1:0] wm);
      int  fr;
      logic b;
      fr = 8 - cnt;
      b  = (fr >= 8 - rx_len(wm));
      return {b, (fr > 0) && !b};
   endfunction

   task automatic check(input string req, input string what, input logic [1:0] act, input logic [1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual burst/single=%b expected=%b", req, what, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic t_reset();
      rst_n = 1'b0; rx_dma_en = 1'b1; tx_dma_en = 1'b1; err_gate_en = 1'b0;
      wmark_sel = 2'b01; rx_count = 4'd8; tx_count = 4'd0; err_flags = '0;
      rx_ack = 1'b0; tx_ack = 1'b0;
      step(); step();
      check("R1", "reset rx", {rx_burst_req, rx_single_req}, 2'b00);
      check("R1", "reset tx", {tx_burst_req, tx_single_req}, 2'b00);
      rst_n = 1'b1;
      step();
   endtask

   task automatic t_rx_levels();
      for (int wm = 0; wm < 4; wm++) begin
         for (int c = 0; c <= 8; c++) begin
            wmark_sel = 2'(wm); rx_count = 4'(c);
            step();
            check((c == 0 || c < rx_len(2'(wm))) ? "R3" : "R2", $sformatf("rx wm=%0d cnt=%0d", wm, c),
                  {rx_burst_req, rx_single_req}, exp_rx(c, 2'(wm)));
            check("R6", "rx exclusive", {1'b0, rx_burst_req & rx_single_req}, 2'b00);
         end
      end
   endtask

   task automatic t_tx_levels();
      for (int wm = 0; wm < 4; wm++) begin
         for (int c = 0; c <= 8; c++) begin
            wmark_sel = 2'(wm); tx_count = 4'(c);
            step();
            check((c == 8 || 8 - c < 8 - rx_len(2'(wm))) ? "R5" : "R4", $sformatf("tx wm=%0d cnt=%0d", wm, c),
                  {tx_burst_req, tx_single_req}, exp_tx(c, 2'(wm)));
         end
      end
   endtask

   task automatic t_disable();
      wmark_sel = 2'b01; rx_count = 4'd8; tx_count = 4'd0;
      rx_dma_en = 1'b0; tx_dma_en = 1'b0;
      step();
      check("R7", "rx disabled", {rx_burst_req, rx_single_req}, 2'b00);
      check("R7", "tx disabled", {tx_burst_req, tx_single_req}, 2'b00);
      rx_dma_en = 1'b1; tx_dma_en = 1'b1;
      step();
      check("R7", "rx reenabled", {rx_burst_req, rx_single_req}, 2'b10);
      check("R7", "tx reenabled", {tx_burst_req, tx_single_req}, 2'b10);
   endtask

   task automatic t_ack();
      wmark_sel = 2'b01; rx_count = 4'd5; tx_count = 4'd1;
      step();
      check("R8", "rx before ack", {rx_burst_req, rx_single_req}, 2'b10);
      rx_ack = 1'b1; tx_ack = 1'b1; rx_count = 4'd1; tx_count = 4'd5;
      step();
      check("R8", "rx ack drop", {rx_burst_req, rx_single_req}, 2'b00);
      check("R8", "tx ack drop", {tx_burst_req, tx_single_req}, 2'b00);
      rx_ack = 1'b0; tx_ack = 1'b0;
      step();
      check("R8", "rx reevaluated", {rx_burst_req, rx_single_req}, 2'b01);
      check("R8", "tx reevaluated", {tx_burst_req, tx_single_req}, 2'b01);
   endtask

   task automatic t_err();
      wmark_sel = 2'b00; rx_count = 4'd3; tx_count = 4'd4;
      err_gate_en = 1'b1;
      for (int b = 0; b < 4; b++) begin
         err_flags = 4'(1 << b);
         step();
         check("R9", $sformatf("rx gated flag %0d", b), {rx_burst_req, rx_single_req}, 2'b00);
         check("R9", $sformatf("tx ungated flag %0d", b), {tx_burst_req, tx_single_req}, 2'b01);
      end
      err_flags = '0;
      step();
      check("R9", "rx recovers", {rx_burst_req, rx_single_req}, 2'b10);
      err_gate_en = 1'b0; err_flags = 4'hF;
      step();
      check("R10", "flags ignored when gating off", {rx_burst_req, rx_single_req}, 2'b10);
      err_flags = '0;
      step();
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      #(20 * 100000);
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      t_reset();
      t_rx_levels();
      t_tx_levels();
      t_disable();
      t_ack();
      t_err();
      finish_run();
   end
endmodule